// File: doc/BRIEF.md
# Parallel flash command interpreter

This block is a synchronous, scaled-down model of the control logic of a byte-wide flash memory. A host drives a parallel bus made of active-low chip-enable, output-enable and write-enable, an address and split write/read data. The block holds a small byte array. Guarded multi-write command sequences program that array, erase it, lock a boot region and switch reads into an identification mode. Each sampled write is one clock edge with the strobes in the write pattern. Each sampled read is one cycle with the strobes in the read pattern.

Program and erase run for a parameterised number of clock cycles. While one runs, reads return a status byte instead of array data. That status byte carries a data-complement flag and a toggling flag, so the host can poll for completion. Addresses below `BOOT_LEN` form the boot region. Once the lockout is set, programming there does nothing and an erase leaves that region intact. Array addresses alias modulo `2**IDX_W`.

Top module: `pflash_ctrl`

## Requirements
- R1: After reset every array byte reads FFh, the lockout is clear, identification mode is off, no operation is running and the command decoder is idle.
- R2: `rd_en` is high exactly when `ce_n`=0, `oe_n`=0 and `we_n`=1, and `rd_data` is 00h whenever `rd_en` is low. A write is taken on a clock edge with `ce_n`=0, `we_n`=0 and `oe_n`=1. With `oe_n`=0 the strobes have no effect.
- R3: Every command opens with AAh written to 5555h, then 55h written to 2AAAh, then a command byte written to 5555h. A write that does not match the expected address and data returns the decoder to idle and performs nothing.
- R4: Command byte A0h arms a program. The next write gives the target address and data, and `PROG_CYC` cycles later the stored byte equals the old byte AND the new data. A data value of F0h in that write is program data, not an exit.
- R5: Command byte 80h is followed by AAh to 5555h, then 55h to 2AAAh, then 10h to 5555h. This starts an erase that, `ERASE_CYC` cycles later, sets every byte to FFh. Boot-region bytes are excluded from the erase while the lockout is set.
- R6: The same 80h extension ending in 40h sets the boot lockout, which only reset clears. While it is set, a program aimed at an address below `BOOT_LEN` changes nothing and starts no operation.
- R7: Command byte 90h enters identification mode. There, reads at address 0, 1 and 2 return 1Fh, 17h and {7'b0, lockout}, and other addresses return 00h. The mode ends on the three-write sequence ending in F0h, or on a single F0h write to any address while the decoder is idle.
- R8: While an operation runs, a read returns bits 5..0 as zero. Bit 7 is the complement of bit 7 of the loaded data when a program runs and the read address equals the program address; otherwise bit 7 is 0.
- R9: While an operation runs, bit 6 of each read is a flag that starts at 0 after reset and inverts after every read cycle. After completion reads return true data.
- R10: Writes that arrive while an operation runs, including on its final cycle, are ignored and leave the decoder state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write strobe, active low |
| addr | input | ADDR_W | Byte address |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data, status byte or identification byte |
| rd_en | output | 1 | High while read data is being driven |

## Verification
The operation counter's completion and a host write can fall on the same clock edge. The write must be dropped there, because the block still counts as busy in that cycle. The bench starts a program and then places an unlock write exactly on the completion edge, followed by the rest of a program sequence. The stored byte must keep its first programmed value. A twin test shifts the same sequence one edge later; there the second program must take effect, which pins the boundary from both sides.

// File: rtl/pflash_pkg.sv
package pflash_pkg;

    localparam logic [7:0] KEY_FIRST  = 8'hAA;
    localparam logic [7:0] KEY_SECOND = 8'h55;
    localparam logic [7:0] CMD_PROG   = 8'hA0;
    localparam logic [7:0] CMD_EXTEND = 8'h80;
    localparam logic [7:0] CMD_ERASE  = 8'h10;
    localparam logic [7:0] CMD_LOCK   = 8'h40;
    localparam logic [7:0] CMD_ID_ON  = 8'h90;
    localparam logic [7:0] CMD_ID_OFF = 8'hF0;
    localparam logic [7:0] ID_MAKER   = 8'h1F;
    localparam logic [7:0] ID_PART    = 8'h17;
    localparam logic [7:0] ERASED     = 8'hFF;
    localparam int unsigned KEY_ADDR_A = 32'h5555;
    localparam int unsigned KEY_ADDR_B = 32'h2AAA;

    typedef enum logic [2:0] {
        DS_IDLE,
        DS_KEY1,
        DS_KEY2,
        DS_PGM,
        DS_EXT1,
        DS_EXT2,
        DS_EXT3
    } dec_st_t;

    typedef enum logic [1:0] {
        OP_NONE,
        OP_PROG,
        OP_ERASE
    } op_t;

    typedef struct packed {
        logic go_prog;
        logic go_erase;
        logic set_lock;
        logic id_on;
        logic id_off;
    } dec_act_t;

    function automatic logic [7:0] id_byte(input logic low_page,
                                           input logic [1:0] sel,
                                           input logic lock);
        logic [7:0] r;
        r = 8'h00;
        if (low_page) begin
            case (sel)
                2'd0:    r = ID_MAKER;
                2'd1:    r = ID_PART;
                2'd2:    r = {7'b0, lock};
                default: r = 8'h00;
            endcase
        end
        return r;
    endfunction

endpackage

// File: rtl/pflash_decode.sv
module pflash_decode
    import pflash_pkg::*;
#(
    parameter int ADDR_W = 17
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_stb,
    input  logic              busy,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output dec_act_t          act,
    output dec_st_t           st
);

    localparam logic [ADDR_W-1:0] A_KEY = ADDR_W'(KEY_ADDR_A);
    localparam logic [ADDR_W-1:0] B_KEY = ADDR_W'(KEY_ADDR_B);

    dec_st_t st_q, st_d;
    logic    at_a, at_b;

    assign at_a = (addr == A_KEY);
    assign at_b = (addr == B_KEY);

    always_comb begin
        st_d = st_q;
        act  = '0;
        if (wr_stb && !busy) begin
            case (st_q)
                DS_IDLE: begin
                    if (at_a && wdata == KEY_FIRST) st_d = DS_KEY1;
                    else if (wdata == CMD_ID_OFF)   act.id_off = 1'b1;
                end
                DS_KEY1: st_d = (at_b && wdata == KEY_SECOND) ? DS_KEY2 : DS_IDLE;
                DS_KEY2: begin
                    st_d = DS_IDLE;
                    if (at_a) begin
                        case (wdata)
                            CMD_PROG:   st_d = DS_PGM;
                            CMD_EXTEND: st_d = DS_EXT1;
                            CMD_ID_ON:  act.id_on  = 1'b1;
                            CMD_ID_OFF: act.id_off = 1'b1;
                            default:    st_d = DS_IDLE;
                        endcase
                    end
                end
                DS_PGM: begin
                    act.go_prog = 1'b1;
                    st_d        = DS_IDLE;
                end
                DS_EXT1: st_d = (at_a && wdata == KEY_FIRST)  ? DS_EXT2 : DS_IDLE;
                DS_EXT2: st_d = (at_b && wdata == KEY_SECOND) ? DS_EXT3 : DS_IDLE;
                DS_EXT3: begin
                    st_d = DS_IDLE;
                    if (at_a && wdata == CMD_ERASE) act.go_erase = 1'b1;
                    if (at_a && wdata == CMD_LOCK)  act.set_lock = 1'b1;
                end
                default: st_d = DS_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= DS_IDLE;
        else     st_q <= st_d;
    end

    assign st = st_q;

endmodule

// File: rtl/pflash_timer.sv
module pflash_timer
    import pflash_pkg::*;
#(
    parameter int PROG_CYC  = 8,
    parameter int ERASE_CYC = 20
) (
    input  logic clk,
    input  logic rst,
    input  logic start_prog,
    input  logic start_erase,
    output logic busy,
    output logic done,
    output op_t  op
);

    localparam int MAX_CYC = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
    localparam int CW      = $clog2(MAX_CYC + 1);

    logic [CW-1:0] cnt_q;
    op_t           op_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            op_q  <= OP_NONE;
        end else if (start_prog) begin
            cnt_q <= CW'(PROG_CYC);
            op_q  <= OP_PROG;
        end else if (start_erase) begin
            cnt_q <= CW'(ERASE_CYC);
            op_q  <= OP_ERASE;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
            if (cnt_q == CW'(1)) op_q <= OP_NONE;
        end
    end

    assign busy = (cnt_q != '0);
    assign done = (cnt_q == CW'(1));
    assign op   = op_q;

endmodule

// File: rtl/pflash_array.sv
module pflash_array #(
    parameter int IDX_W    = 6,
    parameter int BOOT_LEN = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             prog_commit,
    input  logic [IDX_W-1:0] prog_idx,
    input  logic [7:0]       prog_data,
    input  logic             erase_commit,
    input  logic             lock,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [7:0]       rd_byte
);

    localparam int DEPTH = 1 << IDX_W;

    logic [7:0] mem_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_byte
        localparam bit IN_BOOT = (g < BOOT_LEN);
        always_ff @(posedge clk) begin
            if (rst)
                mem_q[g] <= 8'hFF;
            else if (prog_commit && prog_idx == IDX_W'(g))
                mem_q[g] <= mem_q[g] & prog_data;
            else if (erase_commit && !(IN_BOOT && lock))
                mem_q[g] <= 8'hFF;
        end
    end

    assign rd_byte = mem_q[rd_idx];

endmodule

// File: rtl/pflash_ctrl.sv
module pflash_ctrl
    import pflash_pkg::*;
#(
    parameter int ADDR_W    = 17,
    parameter int IDX_W     = 6,
    parameter int BOOT_LEN  = 16,
    parameter int PROG_CYC  = 8,
    parameter int ERASE_CYC = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wr_data,
    output logic [7:0]        rd_data,
    output logic              rd_en
);

    logic              wr_stb, rd_stb, boot_hit;
    logic              busy, done, start_prog;
    logic              lock_q, id_q, tgl_q;
    logic [ADDR_W-1:0] ld_addr_q;
    logic [7:0]        ld_data_q, mem_rd;
    op_t               op;
    dec_act_t          act;
    dec_st_t           dec_st;

    assign wr_stb   = !ce_n && !we_n && oe_n;
    assign rd_stb   = !ce_n && !oe_n && we_n;
    assign boot_hit = (addr < ADDR_W'(BOOT_LEN));

    pflash_decode #(.ADDR_W(ADDR_W)) u_dec (
        .clk(clk), .rst(rst), .wr_stb(wr_stb), .busy(busy),
        .addr(addr), .wdata(wr_data), .act(act), .st(dec_st)
    );

    assign start_prog = act.go_prog && !(lock_q && boot_hit);

    pflash_timer #(.PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)) u_tmr (
        .clk(clk), .rst(rst), .start_prog(start_prog),
        .start_erase(act.go_erase), .busy(busy), .done(done), .op(op)
    );

    pflash_array #(.IDX_W(IDX_W), .BOOT_LEN(BOOT_LEN)) u_arr (
        .clk(clk), .rst(rst),
        .prog_commit(done && op == OP_PROG),
        .prog_idx(ld_addr_q[IDX_W-1:0]), .prog_data(ld_data_q),
        .erase_commit(done && op == OP_ERASE), .lock(lock_q),
        .rd_idx(addr[IDX_W-1:0]), .rd_byte(mem_rd)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            lock_q    <= 1'b0;
            id_q      <= 1'b0;
            tgl_q     <= 1'b0;
            ld_addr_q <= '0;
            ld_data_q <= 8'h00;
        end else begin
            if (act.set_lock) lock_q <= 1'b1;
            if (act.id_on)       id_q <= 1'b1;
            else if (act.id_off) id_q <= 1'b0;
            if (rd_stb && busy) tgl_q <= ~tgl_q;
            if (start_prog) begin
                ld_addr_q <= addr;
                ld_data_q <= wr_data;
            end
        end
    end

    always_comb begin
        rd_data = 8'h00;
        if (rd_stb) begin
            if (busy) begin
                rd_data[7] = (op == OP_PROG && addr == ld_addr_q) ? ~ld_data_q[7] : 1'b0;
                rd_data[6] = tgl_q;
            end else if (id_q) begin
                rd_data = id_byte((addr >> 2) == '0, addr[1:0], lock_q);
            end else begin
                rd_data = mem_rd;
            end
        end
    end

    assign rd_en = rd_stb;

endmodule

// File: rtl/pflash_chk.sv
module pflash_chk
    import pflash_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       ce_n,
    input logic       oe_n,
    input logic       we_n,
    input logic       rd_en,
    input logic [7:0] rd_data,
    input logic       busy,
    input logic       lock,
    input logic       tgl,
    input op_t        op,
    input dec_st_t    dec_st
);

    assert_quiet_bus_R2: assert property (@(posedge clk) disable iff (rst)
        !rd_en |-> rd_data == 8'h00);

    assert_busy_from_write_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(!ce_n && !we_n && oe_n));

    assert_op_tagged_R5: assert property (@(posedge clk) disable iff (rst)
        busy |-> op != OP_NONE);

    assert_lock_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        lock |=> lock);

    assert_status_low_R8: assert property (@(posedge clk) disable iff (rst)
        (busy && rd_en) |-> rd_data[5:0] == 6'd0);

    assert_toggle_R9: assert property (@(posedge clk) disable iff (rst)
        (busy && rd_en) |=> tgl != $past(tgl));

    assert_busy_freeze_R10: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(dec_st));

endmodule

bind pflash_ctrl pflash_chk u_chk (
    .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .rd_en(rd_en), .rd_data(rd_data), .busy(busy), .lock(lock_q),
    .tgl(tgl_q), .op(op), .dec_st(dec_st)
);

// File: tb/pflash_ctrl_tb.sv
module pflash_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
    logic [16:0] addr = '0;
    logic [7:0]  wr_data = '0;
    logic [7:0]  rd_data;
    logic        rd_en;
    int          n_chk = 0;
    int          n_bad = 0;

    always #2 clk = ~clk;

    pflash_ctrl u_dut (
        .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .addr(addr), .wr_data(wr_data), .rd_data(rd_data), .rd_en(rd_en)
    );

    // vector: {req[3:0], kind[1:0], addr[16:0], data[7:0], expect[7:0]}
    // kind 0 = write, 1 = read and compare, 2 = idle for data cycles
    function automatic logic [38:0] vw(input logic [16:0] a, input logic [7:0] d);
        return {4'd0, 2'd0, a, d, 8'd0};
    endfunction
    function automatic logic [38:0] vr(input int r, input logic [16:0] a, input logic [7:0] e);
        return {r[3:0], 2'd1, a, 8'd0, e};
    endfunction
    function automatic logic [38:0] vz(input int n);
        return {4'd0, 2'd2, 17'd0, n[7:0], 8'd0};
    endfunction

    localparam int NV = 78;
    localparam logic [38:0] VEC [NV] = '{
        vr(1, 17'h5, 8'hFF), vr(1, 17'h3F, 8'hFF),                 // R1 erased after reset
        vw(17'h5555, 8'hAA), vw(17'h2AAA, 8'h55), vw(17'h5555, 8'hA0), vw(17'h5, 8'h3C),
        vr(8, 17'h5, 8'h80), vr(9, 17'h5, 8'hC0), vr(8, 17'h6, 8'h00), // R8 complement, R9 toggle
        vz(10), vr(4, 17'h5, 8'h3C),                               // R4 programmed
        vw(17'h5555, 8'hAA), vw(17'h2AAA, 8'h55), vw(17'h5555, 8'hA0), vw(17'h5, 8'hF0),
        vz(10), vr(4, 17'h5, 8'h30),                               // R4 AND, F0 as data
        vw(17'h5555, 8'hAA), vw(17'h2AAA, 8'h55), vw(17'h5555, 8'h90),
        vr(7, 17'h0, 8'h1F), vr(7, 17'h1, 8'h17), vr(7, 17'h2, 8'h00), vr(7, 17'h3, 8'h00), // R7
        vw(17'h123, 8'hF0), vr(7, 17'h5, 8'h30),                   // R7 single-write exit
        vw(17'h5555, 8'hAA), vw(17'h2AAA, 8'h55), vw(17'h1234, 8'hA0), vw(17'h5, 8'h00),
        vz(10), vr(3, 17'h5, 8'h30),                               // R3 wrong command address
        vw(17'h5555, 8'hAA), vw(17'h5555, 8'h55), vw(17'h5555, 8'hA0), vw(17'h7, 8'h00),
        vz(10), vr(3, 17'h7, 8'hFF),                               // R3 wrong second key
        vw(17'h5555, 8'hAA), vw(17'h2AAA, 8'h55), vw(17'h5555, 8'h80),
        vw(17'h5555, 8'hAA), vw(17'h2AAA, 8'h55), vw(17'h5555, 8'h40),
        vw(17'h5555, 8'hAA), vw(17'h2AAA, 8'h55), vw(17'h5555, 8'h90),
        vr(6, 17'h2, 8'h01),                                       // R6 lock reported
        vw(17'h5555, 8'hAA), vw(17'h2AAA, 8'h55), vw(17'h5555, 8'hF0),
        vr(7, 17'h2, 8'hFF),                                       // R7 three-write exit
        vw(17'h5555, 8'hAA), vw(17'h2AAA, 8'h55), vw(17'h5555, 8'hA0), vw(17'h3, 8'h00),
        vr(6, 17'h3, 8'hFF),                                       // R6 boot program dropped, not busy
        vw(17'h5555, 8'hAA), vw(17'h2AAA, 8'h55), vw(17'h5555, 8'hA0), vw(17'h14, 8'h0F),
        vz(10), vr(4, 17'h14, 8'h0F),
        vw(17'h5555, 8'hAA), vw(17'h2AAA, 8'h55), vw(17'h5555, 8'h80),
        vw(17'h5555, 8'hAA), vw(17'h2AAA, 8'h55), vw(17'h5555, 8'h10),
        vr(8, 17'h14, 8'h40),                                      // R8 erase status
        vw(17'h5555, 8'hAA), vw(17'h2AAA, 8'h55), vw(17'h5555, 8'hA0), vw(17'h14, 8'h00), // R10
        vz(25), vr(5, 17'h14, 8'hFF), vr(6, 17'h5, 8'h30), vr(5, 17'h3F, 8'hFF) // R5, R6
    };

    task automatic report();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    endtask

    task automatic check(input int r, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL R%0d actual=%02h expected=%02h at %0t", r, act, exp, $time);
        end
    endtask

    task automatic run_vec(input logic [38:0] v);
        logic [3:0]  r;
        logic [1:0]  k;
        logic [16:0] a;
        logic [7:0]  d, e;
        {r, k, a, d, e} = v;
        if (k == 2'd0) begin
            ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1; addr = a; wr_data = d;
            @(negedge clk);
        end else if (k == 2'd1) begin
            ce_n = 1'b0; we_n = 1'b1; oe_n = 1'b0; addr = a;
            #1;
            check(int'(r), rd_en ? rd_data : 8'hXX, e);
            @(negedge clk);
        end else begin
            ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
            repeat (int'(d)) @(negedge clk);
        end
        ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
    endtask

    task automatic prog(input logic [16:0] a, input logic [7:0] d);
        run_vec(vw(17'h5555, 8'hAA));
        run_vec(vw(17'h2AAA, 8'h55));
        run_vec(vw(17'h5555, 8'hA0));
        run_vec(vw(a, d));
    endtask

    initial begin
        #600000;
        n_bad++;
        $display("FAIL watchdog expired");
        report();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        check(2, {7'd0, rd_en}, 8'h00);           // R2 idle bus drives nothing
        check(2, rd_data, 8'h00);
        @(negedge clk);

        for (int i = 0; i < NV; i++) run_vec(VEC[i]);

        // R2: read strobe decoding
        ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1; addr = 17'h14; #1;
        check(2, {7'd0, rd_en}, 8'h01);
        ce_n = 1'b1; #1;
        check(2, {7'd0, rd_en}, 8'h00);
        check(2, rd_data, 8'h00);
        @(negedge clk);

        // R2: strobes with oe_n low do not write
        foreach (VEC[j]) begin end
        ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b0;
        addr = 17'h5555; wr_data = 8'hAA; @(negedge clk);
        addr = 17'h2AAA; wr_data = 8'h55; @(negedge clk);
        addr = 17'h5555; wr_data = 8'hA0; @(negedge clk);
        addr = 17'h14;   wr_data = 8'h00; @(negedge clk);
        ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
        run_vec(vz(12));
        run_vec(vr(2, 17'h14, 8'hFF));

        // R10: write on the completion edge is dropped
        prog(17'h22, 8'h7F);
        run_vec(vz(7));
        prog(17'h22, 8'h00);
        run_vec(vz(12));
        run_vec(vr(10, 17'h22, 8'h7F));

        // R10 twin: one edge later the sequence is accepted
        prog(17'h23, 8'h7F);
        run_vec(vz(8));
        prog(17'h23, 8'h0F);
        run_vec(vz(12));
        run_vec(vr(10, 17'h23, 8'h0F));

        // R1: reset in the middle of an erase
        run_vec(vw(17'h5555, 8'hAA)); run_vec(vw(17'h2AAA, 8'h55)); run_vec(vw(17'h5555, 8'h80));
        run_vec(vw(17'h5555, 8'hAA)); run_vec(vw(17'h2AAA, 8'h55)); run_vec(vw(17'h5555, 8'h10));
        run_vec(vz(3));
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        run_vec(vr(1, 17'h5, 8'hFF));
        run_vec(vr(1, 17'h14, 8'hFF));
        run_vec(vw(17'h5555, 8'hAA)); run_vec(vw(17'h2AAA, 8'h55)); run_vec(vw(17'h5555, 8'h90));
        run_vec(vr(1, 17'h2, 8'h00));              // R1 lock cleared

        report();
        $finish;
    end

endmodule